// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-up to a state in which normal accesses may begin. After reset it holds the clock enable low and waits in an idle state until an external input reports that the power and clock stabilization interval is over. It then drives a fixed bring-up sequence onto the memory command bus. The sequence is one clock of NOP, a precharge of all banks, a load of the extended mode register that enables the DLL, and a mode register load that resets the DLL. These are followed by a second precharge of all banks, two auto-refresh commands and a final mode register load that sets the operating mode.

Between commands the sequencer holds NOP for as many clocks as the tRP, tRFC and tMRD delays require. Each count is derived at elaboration from nanosecond parameters and the clock period. When the clock period alone already covers a delay, the wait state for that delay is skipped. Once the last delay has elapsed, an init-done flag rises and stays high until reset. A read/write controller would use this flag to take over the command bus.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted, and afterwards until `stable_done` is sampled high in the idle state, the outputs show CKE low, the NOP code and `init_done` low. Reset asserted at any point in the sequence returns the block to this state.
- R2: The clock edge that samples `stable_done` high begins exactly one clock of NOP with CKE high. The precharge-all command appears on the bus two clocks after that edge, and CKE stays high from then on.
- R3: The non-NOP commands appear in this order: PRECHARGE, LOAD MODE (extended), LOAD MODE (DLL reset), PRECHARGE, AUTO REFRESH, AUTO REFRESH, LOAD MODE (final). The {cs_n, ras_n, cas_n, we_n} codes are NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001 and LOAD MODE 0000.
- R4: Each PRECHARGE drives address bit 10 high with every other address bit and the bank address zero. Each AUTO REFRESH drives address and bank address zero.
- R5: The extended mode load drives bank address 01 and the `EXT_MODE` word on the address bus.
- R6: Both base mode loads drive bank address 00 and the mode word, with burst length code in bits 2:0, burst type in bit 3, CAS latency code in bits 6:4 and operating mode in bits 12:7. The DLL-reset load additionally sets bit 8, and the final load leaves bit 8 clear.
- R7: The clock distance from each PRECHARGE to the next command is max(1, ceil(tRP/tCK)). The distance from each AUTO REFRESH to the next command is max(1, ceil(tRFC/tCK)). The distance from the final mode load to the rise of `init_done` is max(1, ceil(tMRD/tCK)). Every other pair of adjacent steps is one clock apart, and only NOP appears in between.
- R8: When a delay does not exceed tCK, its wait state is skipped and the next command follows on the very next clock.
- R9: Once `init_done` is high it stays high with NOP on the bus and CKE high until reset, whatever `stable_done` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stable_done | input | 1 | High once the power/clock stabilization delay has elapsed |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Row / mode-word address bus |
| init_done | output | 1 | High once bring-up is complete |

## Verification
The assertions take for granted only that `stable_done` is synchronous to `clk` and meets setup at the edge that samples it. They make no assumption that it stays high after it first rises, or that it is ever low after initialization. The bench drives `stable_done` and reset only on falling edges. It lowers `stable_done` again after the sequence completes, and it pulses reset in the middle of a sequence. This exercises both the hold conditions and the sticky ready state without breaking the setup assumption. Two instances with different clock periods and mode fields cover the counted waits and the skipped waits.

// File: rtl/ddrinit_pkg.sv
package ddrinit_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR  = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_NOP  = 4'b0111
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_NOP,
    ST_PRE1,
    ST_WRP1,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PRE2,
    ST_WRP2,
    ST_AREF1,
    ST_WRFC1,
    ST_AREF2,
    ST_WRFC2,
    ST_MRS,
    ST_WMRD,
    ST_READY
  } init_state_e;

  // Clock distance needed to cover t_ns at period tck_ns, never below one.
  function automatic int unsigned clocks_for(input int unsigned t_ns,
                                             input int unsigned tck_ns);
    int unsigned n;
    n = (t_ns + tck_ns - 1) / tck_ns;
    return (n < 1) ? 1 : n;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Mode word: [2:0] burst length, [3] burst type, [6:4] CAS latency, [12:7] op mode.
  function automatic logic [12:0] mode_word(input logic [2:0] bl,
                                            input logic       bt,
                                            input logic [2:0] cl,
                                            input logic [5:0] op);
    return {op, cl, bt, bl};
  endfunction

endpackage

// File: rtl/ddrinit_wait_timer.sv
module ddrinit_wait_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      cnt   <= load_val;
      armed <= 1'b1;
    end else if (armed) begin
      if (cnt == '0) armed <= 1'b0;
      else           cnt   <= cnt - ONE;
    end
  end

  assign expired = armed && (cnt == '0);

  assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (cnt != '0) && !load) |=> (cnt == $past(cnt) - ONE));

  assert_load_takes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (armed && cnt == $past(load_val)));

endmodule

// File: rtl/ddrinit_cmd_encode.sv
module ddrinit_cmd_encode
  import ddrinit_pkg::*;
#(
  parameter int          ADDR_W    = 13,
  parameter int          BA_W      = 2,
  parameter logic [12:0] EXT_WORD  = 13'h0000,
  parameter logic [12:0] BASE_WORD = 13'h0022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  init_state_e       state,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              done
);

  localparam int AP_BIT      = 10;
  localparam int DLL_RST_BIT = 8;
  localparam logic [ADDR_W-1:0] AP_MASK  = ADDR_W'(1) << AP_BIT;
  localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] EXT_A    = ADDR_W'(EXT_WORD);
  localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_WORD) & ~DLL_MASK;
  localparam logic [BA_W-1:0]   BA_EXT   = BA_W'(1);

  ddr_cmd_e          cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;
  logic              cke_d;
  logic              done_d;
  logic              wait_state;

  assign wait_state = (state == ST_WRP1) || (state == ST_WRP2) ||
                      (state == ST_WRFC1) || (state == ST_WRFC2) ||
                      (state == ST_WMRD);

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    cke_d  = (state != ST_IDLE);
    done_d = (state == ST_READY);
    case (state)
      ST_PRE1, ST_PRE2: begin
        cmd_d  = CMD_PRE;
        addr_d = AP_MASK;
      end
      ST_EMRS: begin
        cmd_d  = CMD_LMR;
        ba_d   = BA_EXT;
        addr_d = EXT_A;
      end
      ST_MRS_DLL: begin
        cmd_d  = CMD_LMR;
        addr_d = BASE_A | DLL_MASK;
      end
      ST_AREF1, ST_AREF2: cmd_d = CMD_AREF;
      ST_MRS: begin
        cmd_d  = CMD_LMR;
        addr_d = BASE_A;
      end
      default: cmd_d = CMD_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      cke  <= 1'b0;
      ba   <= '0;
      addr <= '0;
      done <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_d;
      cke  <= cke_d;
      ba   <= ba_d;
      addr <= addr_d;
      done <= done_d;
    end
  end

  assert_wait_is_nop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_state |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  assert_ready_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READY) |=> (done && cke && {cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  assert_idle_cke_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |=> (!cke && !done));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddrinit_pkg::*;
#(
  parameter int unsigned TCK_NS           = 8,
  parameter int unsigned TRP_NS           = 20,
  parameter int unsigned TRFC_NS          = 75,
  parameter int unsigned TMRD_NS          = 12,
  parameter int          ADDR_W           = 13,
  parameter int          BA_W             = 2,
  parameter logic [2:0]  BL_CODE          = 3'b010,
  parameter logic        BURST_INTERLEAVE = 1'b0,
  parameter logic [2:0]  CL_CODE          = 3'b010,
  parameter logic [5:0]  OP_MODE          = 6'b000000,
  parameter logic [12:0] EXT_MODE         = 13'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stable_done,
  output logic              mem_cke,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic [BA_W-1:0]   mem_ba,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              init_done
);

  localparam int unsigned RP_N  = clocks_for(TRP_NS, TCK_NS);
  localparam int unsigned RFC_N = clocks_for(TRFC_NS, TCK_NS);
  localparam int unsigned MRD_N = clocks_for(TMRD_NS, TCK_NS);
  localparam int unsigned MAX_N = max3(RP_N, RFC_N, MRD_N);
  localparam int          CNT_W = (MAX_N > 2) ? $clog2(MAX_N) : 1;

  localparam bit RP_WAIT  = (RP_N > 1);
  localparam bit RFC_WAIT = (RFC_N > 1);
  localparam bit MRD_WAIT = (MRD_N > 1);

  // Wait state lasts N-1 clocks; the timer reaches zero on its last one.
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_WAIT  ? RP_N  - 2 : 0);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(RFC_WAIT ? RFC_N - 2 : 0);
  localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(MRD_WAIT ? MRD_N - 2 : 0);

  localparam logic [12:0] BASE_WORD = mode_word(BL_CODE, BURST_INTERLEAVE, CL_CODE, OP_MODE);

  init_state_e      state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             in_wait;

  assign in_wait = (state_q == ST_WRP1) || (state_q == ST_WRP2) ||
                   (state_q == ST_WRFC1) || (state_q == ST_WRFC2) ||
                   (state_q == ST_WMRD);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE:    if (stable_done) state_d = ST_NOP;
      ST_NOP:     state_d = ST_PRE1;
      ST_PRE1: begin
        if (RP_WAIT) begin
          state_d  = ST_WRP1;
          tmr_load = 1'b1;
          tmr_val  = RP_LD;
        end else begin
          state_d = ST_EMRS;
        end
      end
      ST_WRP1:    if (tmr_expired) state_d = ST_EMRS;
      ST_EMRS:    state_d = ST_MRS_DLL;
      ST_MRS_DLL: state_d = ST_PRE2;
      ST_PRE2: begin
        if (RP_WAIT) begin
          state_d  = ST_WRP2;
          tmr_load = 1'b1;
          tmr_val  = RP_LD;
        end else begin
          state_d = ST_AREF1;
        end
      end
      ST_WRP2:    if (tmr_expired) state_d = ST_AREF1;
      ST_AREF1: begin
        if (RFC_WAIT) begin
          state_d  = ST_WRFC1;
          tmr_load = 1'b1;
          tmr_val  = RFC_LD;
        end else begin
          state_d = ST_AREF2;
        end
      end
      ST_WRFC1:   if (tmr_expired) state_d = ST_AREF2;
      ST_AREF2: begin
        if (RFC_WAIT) begin
          state_d  = ST_WRFC2;
          tmr_load = 1'b1;
          tmr_val  = RFC_LD;
        end else begin
          state_d = ST_MRS;
        end
      end
      ST_WRFC2:   if (tmr_expired) state_d = ST_MRS;
      ST_MRS: begin
        if (MRD_WAIT) begin
          state_d  = ST_WMRD;
          tmr_load = 1'b1;
          tmr_val  = MRD_LD;
        end else begin
          state_d = ST_READY;
        end
      end
      ST_WMRD:    if (tmr_expired) state_d = ST_READY;
      ST_READY:   state_d = ST_READY;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  ddrinit_wait_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  ddrinit_cmd_encode #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .EXT_WORD  (EXT_MODE),
    .BASE_WORD (BASE_WORD)
  ) u_encode (
    .clk   (clk),
    .rst_n (rst_n),
    .state (state_q),
    .cke   (mem_cke),
    .cs_n  (mem_cs_n),
    .ras_n (mem_ras_n),
    .cas_n (mem_cas_n),
    .we_n  (mem_we_n),
    .ba    (mem_ba),
    .addr  (mem_addr),
    .done  (init_done)
  );

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !stable_done) |=> (state_q == ST_IDLE));

  assert_nop_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NOP) |=> (state_q == ST_PRE1));

  assert_wait_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && !tmr_expired) |=> (state_q == $past(state_q)));

  assert_ready_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY) |=> (state_q == ST_READY));

  assert_cke_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke |=> mem_cke);

endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] stable = 2'b00;
  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  // Per-instance settings, restated here for the expected values.
  localparam int TCK_A [2] = '{8, 30};
  localparam int TRP_A [2] = '{20, 20};
  localparam int TRFC_A[2] = '{75, 75};
  localparam int TMRD_A[2] = '{12, 12};
  localparam int BL_A  [2] = '{2, 3};
  localparam int BT_A  [2] = '{0, 1};
  localparam int CL_A  [2] = '{2, 6};
  localparam int OP_A  [2] = '{0, 0};
  localparam int EXT_A [2] = '{0, 2};

  // Step table: {cmd[3:0], ba[1:0], addr_sel[2:0], gap_sel[1:0]}
  // addr_sel: 0 zero, 1 bit10, 2 ext word, 3 mode|bit8, 4 mode
  // gap_sel: 0 one clock, 1 tRP, 2 tRFC, 3 tMRD (to init_done)
  localparam logic [10:0] STEPS [7] = '{
    {4'b0010, 2'b00, 3'd1, 2'd1},
    {4'b0000, 2'b01, 3'd2, 2'd0},
    {4'b0000, 2'b00, 3'd3, 2'd0},
    {4'b0010, 2'b00, 3'd1, 2'd1},
    {4'b0001, 2'b00, 3'd0, 2'd2},
    {4'b0001, 2'b00, 3'd0, 2'd2},
    {4'b0000, 2'b00, 3'd4, 2'd3}
  };

  logic [20:0] obs [2];
  logic        cke0, cs0, ras0, cas0, we0, done0;
  logic [1:0]  ba0;
  logic [12:0] addr0;
  logic        cke1, cs1, ras1, cas1, we1, done1;
  logic [1:0]  ba1;
  logic [12:0] addr1;

  ddr_init_seq uut (
    .clk(clk), .rst_n(rst_n), .stable_done(stable[0]),
    .mem_cke(cke0), .mem_cs_n(cs0), .mem_ras_n(ras0), .mem_cas_n(cas0),
    .mem_we_n(we0), .mem_ba(ba0), .mem_addr(addr0), .init_done(done0)
  );

  ddr_init_seq #(
    .TCK_NS(30), .BL_CODE(3'b011), .BURST_INTERLEAVE(1'b1),
    .CL_CODE(3'b110), .EXT_MODE(13'h0002)
  ) uut_slow (
    .clk(clk), .rst_n(rst_n), .stable_done(stable[1]),
    .mem_cke(cke1), .mem_cs_n(cs1), .mem_ras_n(ras1), .mem_cas_n(cas1),
    .mem_we_n(we1), .mem_ba(ba1), .mem_addr(addr1), .init_done(done1)
  );

  // [20] done, [19] cke, [18:15] cmd, [14:13] ba, [12:0] addr
  assign obs[0] = {done0, cke0, cs0, ras0, cas0, we0, ba0, addr0};
  assign obs[1] = {done1, cke1, cs1, ras1, cas1, we1, ba1, addr1};

  task automatic check(input bit ok, input string req, input string what,
                       input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, actual, expected);
    end
  endtask

  function automatic int need_clocks(input int t, input int tck);
    int n = 0;
    while (n * tck < t) n++;
    if (n == 0) n = 1;
    return n;
  endfunction

  function automatic int base_word(input int w);
    return BL_A[w] + 8 * BT_A[w] + 16 * CL_A[w] + 128 * OP_A[w];
  endfunction

  function automatic int step_addr(input int w, input int sel);
    case (sel)
      1: return 1024;
      2: return EXT_A[w];
      3: return base_word(w) + 256;
      4: return base_word(w);
      default: return 0;
    endcase
  endfunction

  function automatic int step_gap(input int w, input int sel);
    case (sel)
      1: return need_clocks(TRP_A[w], TCK_A[w]);
      2: return need_clocks(TRFC_A[w], TCK_A[w]);
      3: return need_clocks(TMRD_A[w], TCK_A[w]);
      default: return 1;
    endcase
  endfunction

  task automatic check_idle(input int w, input string req);
    check(obs[w][19] == 1'b0, req, "cke low in idle", obs[w][19], 0);
    check(obs[w][18:15] == 4'b0111, req, "NOP in idle", obs[w][18:15], 4'b0111);
    check(obs[w][20] == 1'b0, req, "init_done low in idle", obs[w][20], 0);
  endtask

  task automatic run_trace(input int w);
    int ev_cyc [16];
    logic [20:0] ev_val [16];
    int nev = 0;
    int done_cyc = -1;
    int t;
    bit cke_seen_ok = 1;
    stable[w] = 1'b1;
    for (int c = 1; c <= 60; c++) begin
      @(negedge clk);
      if (c == 1) check(obs[w][19] == 1'b0, "R2", "cke low at first edge", obs[w][19], 0);
      if (c == 2) begin
        check(obs[w][19] == 1'b1, "R2", "cke high with NOP", obs[w][19], 1);
        check(obs[w][18:15] == 4'b0111, "R2", "NOP clock", obs[w][18:15], 4'b0111);
      end
      if (c >= 2 && !obs[w][19]) cke_seen_ok = 0;
      if (obs[w][18:15] != 4'b0111 && nev < 16) begin
        ev_cyc[nev] = c;
        ev_val[nev] = obs[w];
        nev++;
      end
      if (obs[w][20] && done_cyc < 0) done_cyc = c;
    end
    check(cke_seen_ok, "R2", "cke stays high", cke_seen_ok, 1);
    check(nev == 7, "R3", "non-NOP command count", nev, 7);
    t = 3;
    for (int s = 0; s < 7; s++) begin
      if (s < nev) begin
        check(ev_val[s][18:15] == STEPS[s][10:7], "R3", $sformatf("step %0d command", s),
              ev_val[s][18:15], STEPS[s][10:7]);
        check(ev_val[s][14:13] == STEPS[s][6:5], "R5", $sformatf("step %0d bank", s),
              ev_val[s][14:13], STEPS[s][6:5]);
        check(int'(ev_val[s][12:0]) == step_addr(w, int'(STEPS[s][4:2])),
              (STEPS[s][4:2] >= 3) ? "R6" : "R4", $sformatf("step %0d address", s),
              ev_val[s][12:0], step_addr(w, int'(STEPS[s][4:2])));
        check(ev_cyc[s] == t, (w == 1) ? "R8" : "R7", $sformatf("step %0d cycle", s),
              ev_cyc[s], t);
      end
      t = t + step_gap(w, int'(STEPS[s][1:0]));
    end
    check(done_cyc == t, (w == 1) ? "R8" : "R7", "init_done cycle", done_cyc, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    check_idle(0, "R1");
    check_idle(1, "R1");
    rst_n = 1'b1;
    ok = 1;
    repeat (10) begin
      @(negedge clk);
      if (obs[0][19] || obs[0][20] || obs[0][18:15] != 4'b0111) ok = 0;
    end
    check(ok, "R1", "idle held while stable_done low", ok, 1);

    run_trace(0);

    // R9: ready is sticky whatever stable_done does
    stable[0] = 1'b0;
    ok = 1;
    repeat (12) begin
      @(negedge clk);
      if (!obs[0][20] || !obs[0][19] || obs[0][18:15] != 4'b0111) ok = 0;
    end
    check(ok, "R9", "ready holds NOP and done after stable_done drops", ok, 1);

    run_trace(1);

    // R1: reset mid-sequence
    stable[0] = 1'b1;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(obs[0][19] == 1'b1, "R2", "sequence running before reset", obs[0][19], 1);
    rst_n = 1'b0;
    stable[0] = 1'b0;
    @(negedge clk);
    check_idle(0, "R1");
    rst_n = 1'b1;
    ok = 1;
    repeat (8) begin
      @(negedge clk);
      if (obs[0][19] || obs[0][20] || obs[0][18:15] != 4'b0111) ok = 0;
    end
    check(ok, "R1", "idle after mid-sequence reset", ok, 1);

    run_trace(0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule